// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a stream of stereo PCM pairs into a serial audio line. Each frame has a left slot and a right slot, and each slot is `SLOT_W` bit clocks long. It drives a serial data line and, when it owns the clocks, a bit clock and a frame clock. The block takes one pair of `SAMPLE_W`-bit samples per frame through a valid/ready handshake. A two-entry nibble map decides which incoming sample goes into which slot. A channel-count field can mute the right slot.

It supports three ways of placing the sample inside a slot: I2S, left-justified and right-justified. Either clock can be inverted. The block can run as the clock owner or as a follower. As clock owner, it advances its bit clock by half a period on each `bclk_tick` pulse from an external divider. As follower, it synchronizes external bit and frame clocks into its own clock domain. It finds the start of a frame on the first left-channel edge after it is enabled. Nothing is shifted unless both the global enable and the transmit enable are high.

Top module: `i2s_tx`

## Requirements
- R1: While `glb_en` or `tx_en` is low, `sd_o` is 0, `s_ready` is 0 and `underrun_o` is 0. In clock-owner mode, `bclk_o` and `lrclk_o` also stay at their idle levels: `bclk_inv` and `lrclk_inv` respectively.
- R2: With `frame_fmt` = 0, and also with the reserved value 3, sample bit `SAMPLE_W-1` is sent in bit period 1 of the slot, after one zero bit in period 0. The following bits come in descending order, and the rest of the slot is 0.
- R3: With `frame_fmt` = 1, sample bit `SAMPLE_W-1` is sent in bit period 0 of the slot, followed by the lower bits in descending order. The rest of the slot is 0.
- R4: With `frame_fmt` = 2, the first `SLOT_W-SAMPLE_W` bit periods of the slot are 0, and sample bit 0 is sent in the last bit period of the slot.
- R5: With `bclk_inv` = 1, the bit clock is inverted. Data changes on the rising pin edge and is stable at the falling pin edge. With `bclk_inv` = 0, data changes on the falling edge and is stable at the rising edge.
- R6: The normalized frame clock is the pin level XOR `lrclk_inv`. A normalized value of 0 marks the left slot and 1 marks the right slot.
- R7: With `slave_mode` = 0, `bclk_o` toggles only in cycles that follow a `bclk_tick` pulse. Each slot lasts exactly `SLOT_W` bit periods. The frame clock changes together with the launching edge of bit period 0.
- R8: With `slave_mode` = 1, the block takes its timing from `ext_bclk` and `ext_lrclk` and drives `bclk_o` and `lrclk_o` to 0. Framing starts at the first change of the normalized frame clock from right to left after enable.
- R9: Slot 0 (left) carries incoming sample `chan_map[3:0]` and slot 1 (right) carries `chan_map[7:4]`. Incoming sample 0 is `s_data[SAMPLE_W-1:0]` and sample 1 is `s_data[2*SAMPLE_W-1:SAMPLE_W]`. An index of 2 or more sends zeros in that slot.
- R10: `chan_cnt` holds the number of active slots minus one. When it is 0, the right slot carries zeros.
- R11: `s_ready` is high for exactly one cycle per frame, at the launch of bit period 0 of the left slot. A pair accepted in that cycle is sent in the same frame.
- R12: If `s_valid` is low at the frame boundary, the whole frame carries zeros and `underrun_o` is 1 for that frame. A frame that receives a pair clears `underrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global block enable |
| tx_en | input | 1 | Transmit enable |
| slave_mode | input | 1 | 0: block drives the clocks, 1: block follows external clocks |
| bclk_inv | input | 1 | Bit-clock inversion |
| lrclk_inv | input | 1 | Frame-clock inversion |
| frame_fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 treated as 0 |
| chan_cnt | input | 3 | Active slots minus one |
| chan_map | input | 8 | Nibble per slot: incoming sample index |
| bclk_tick | input | 1 | Half-period pulse from the bit-clock divider (clock-owner mode) |
| ext_bclk | input | 1 | External bit clock (follower mode) |
| ext_lrclk | input | 1 | External frame clock (follower mode) |
| s_data | input | 2*SAMPLE_W | Stereo pair, sample 0 in the low half |
| s_valid | input | 1 | Pair available |
| s_ready | output | 1 | Pair taken at this frame boundary |
| bclk_o | output | 1 | Bit clock out |
| lrclk_o | output | 1 | Frame clock out |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Current frame had no pair and carries zeros |

## Verification
The bench acts as a receiver. It captures `sd_o` on every capture edge and checks each slot against a word it builds from the pair it saw handed over. Format errors are caught this way: a one-bit offset in I2S framing, or a missing zero pad in right-justified mode, shifts the whole captured word. A stale pair held for one frame too long gives a wrong left word in every frame. The bench also checks that an inverted clock is captured on the correct edge, that a muted or out-of-range slot is silent, and that a missing pair gives a zero frame with the underrun flag set. In follower mode it checks that framing locks to the first left edge and that the clock outputs stay low. Turning off either enable in the middle of a frame must silence the data line and end the handshake at once.

// File: rtl/i2s_tx.sv
module i2s_tx #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glb_en,
  input  logic                  tx_en,
  input  logic                  slave_mode,
  input  logic                  bclk_inv,
  input  logic                  lrclk_inv,
  input  logic [1:0]            frame_fmt,
  input  logic [2:0]            chan_cnt,
  input  logic [7:0]            chan_map,
  input  logic                  bclk_tick,
  input  logic                  ext_bclk,
  input  logic                  ext_lrclk,
  input  logic [2*SAMPLE_W-1:0] s_data,
  input  logic                  s_valid,
  output logic                  s_ready,
  output logic                  bclk_o,
  output logic                  lrclk_o,
  output logic                  sd_o,
  output logic                  underrun_o
);
  localparam int PW  = $clog2(SLOT_W);
  localparam int PAD = SLOT_W - SAMPLE_W;

  logic                  bclk_q, half_q, run_q, prev_lr_q, sd_q, urun_q;
  logic [PW-1:0]         pos_q;
  logic [2*SAMPLE_W-1:0] pair_q;
  logic [2:0]            bsync_q;
  logic [1:0]            lsync_q;

  logic                  nx_run, nx_half, bound, tx_bit;
  logic [PW-1:0]         nx_pos, rev;
  logic [2*SAMPLE_W-1:0] src;
  logic [3:0]            idx;
  logic [SAMPLE_W-1:0]   smp;
  logic [SLOT_W-1:0]     word;

  wire active = glb_en & tx_en;
  wire bn_new = bsync_q[1] ^ bclk_inv;
  wire bn_old = bsync_q[2] ^ bclk_inv;
  wire lr_ext = lsync_q[1] ^ lrclk_inv;
  wire launch = active & (slave_mode ? (bn_old & ~bn_new) : (bclk_tick & bclk_q));

  always_comb begin
    nx_run  = run_q;
    nx_half = half_q;
    nx_pos  = pos_q;
    bound   = 1'b0;
    if (!slave_mode) begin
      if (!run_q) begin
        nx_run = 1'b1; nx_half = 1'b0; nx_pos = '0; bound = 1'b1;
      end else if (pos_q == PW'(SLOT_W-1)) begin
        nx_pos = '0; nx_half = ~half_q; bound = half_q;
      end else begin
        nx_pos = pos_q + 1'b1;
      end
    end else begin
      if (!run_q) begin
        if (prev_lr_q && !lr_ext) begin
          nx_run = 1'b1; nx_half = 1'b0; nx_pos = '0; bound = 1'b1;
        end
      end else if (lr_ext != half_q) begin
        nx_half = lr_ext; nx_pos = '0; bound = ~lr_ext;
      end else if (pos_q != PW'(SLOT_W-1)) begin
        nx_pos = pos_q + 1'b1;
      end
    end
  end

  assign src = bound ? (s_valid ? s_data : '0) : pair_q;
  assign idx = nx_half ? chan_map[7:4] : chan_map[3:0];

  always_comb begin
    smp = '0;
    if ((!nx_half || chan_cnt != 3'd0) && idx < 4'd2)
      smp = idx[0] ? src[2*SAMPLE_W-1:SAMPLE_W] : src[SAMPLE_W-1:0];
    case (frame_fmt)
      2'd1:    word = SLOT_W'(smp) << PAD;
      2'd2:    word = SLOT_W'(smp);
      default: word = (SLOT_W'(smp) << PAD) >> 1;
    endcase
  end

  assign rev    = PW'(SLOT_W-1) - nx_pos;
  assign tx_bit = word[rev];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync_q <= '0; lsync_q <= '0;
      bclk_q <= 1'b0; half_q <= 1'b0; run_q <= 1'b0; prev_lr_q <= 1'b0;
      sd_q <= 1'b0; urun_q <= 1'b0; pos_q <= '0; pair_q <= '0;
    end else begin
      bsync_q <= {bsync_q[1:0], ext_bclk};
      lsync_q <= {lsync_q[0], ext_lrclk};
      if (!active) begin
        bclk_q <= 1'b0; half_q <= 1'b0; run_q <= 1'b0; prev_lr_q <= 1'b0;
        sd_q <= 1'b0; urun_q <= 1'b0; pos_q <= '0;
      end else begin
        if (!slave_mode && bclk_tick) bclk_q <= ~bclk_q;
        if (launch) begin
          run_q     <= nx_run;
          half_q    <= nx_half;
          pos_q     <= nx_pos;
          prev_lr_q <= lr_ext;
          sd_q      <= nx_run & tx_bit;
          if (bound) begin
            pair_q <= src;
            urun_q <= ~s_valid;
          end
        end
      end
    end
  end

  assign s_ready    = launch & bound;
  assign sd_o       = sd_q;
  assign underrun_o = urun_q;
  assign bclk_o     = slave_mode ? 1'b0 : (bclk_q ^ bclk_inv);
  assign lrclk_o    = slave_mode ? 1'b0 : (half_q ^ lrclk_inv);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sd_o);
  // R7
  bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !slave_mode && !bclk_tick) |=>
      (!active || slave_mode || (bclk_inv != $past(bclk_inv)) || $stable(bclk_o)));
  // R11
  boundary_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> (pos_q == '0 && !half_q && run_q));
  // R12
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> underrun_o);
  // R12
  underrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> !underrun_o);
  // R10
  mute_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && nx_half && chan_cnt == 3'd0) |=> !sd_o);
endmodule

// File: tb/i2s_tx_tb_top.sv
module i2s_tx_tb_top;
  localparam int SW = 16;
  localparam int LW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 0, tx_en = 0, slave_c = 0, binv_c = 0, lrinv_c = 0;
  logic [1:0] fmt_c = 0;
  logic [2:0] cnt_c = 3'd1;
  logic [7:0] map_c = 8'h10;
  logic bclk_tick = 0, ext_bclk = 0, ext_lrclk = 0, s_valid = 0;
  logic [2*SW-1:0] s_data = '0;
  logic s_ready, bclk_o, lrclk_o, sd_o, underrun_o;

  int checks = 0, errors = 0, starve = 0, tick_cnt = 0;
  string ptag = "R2";

  i2s_tx #(.SAMPLE_W(SW), .SLOT_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en),
    .slave_mode(slave_c), .bclk_inv(binv_c), .lrclk_inv(lrinv_c),
    .frame_fmt(fmt_c), .chan_cnt(cnt_c), .chan_map(map_c),
    .bclk_tick(bclk_tick), .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sd_o(sd_o), .underrun_o(underrun_o));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] exp_word(input logic [2*SW-1:0] pair, input int h,
      input logic [1:0] fmt, input logic [7:0] map, input logic [2:0] cnt);
    logic [3:0] ix;
    logic [SW-1:0] s;
    logic [LW-1:0] w;
    ix = (h == 0) ? map[3:0] : map[7:4];
    s = '0;
    if ((h == 0 || cnt != 0) && ix < 2) s = (ix == 0) ? pair[SW-1:0] : pair[2*SW-1:SW];
    w = '0;
    for (int b = 0; b < SW; b++) begin
      int p;
      case (fmt)
        2'd1: p = b;
        2'd2: p = LW - SW + b;
        default: p = b + 1;
      endcase
      w[LW-1-p] = s[SW-1-b];
    end
    return w;
  endfunction

  // stimulus drivers, one time unit after the rising edge
  always @(posedge clk) begin
    #1;
    tick_cnt = (tick_cnt == 2) ? 0 : tick_cnt + 1;
    bclk_tick = (tick_cnt == 2);
    s_data = $urandom;
    s_valid = (starve == 0) ? 1'b1 : (starve == 1) ? 1'b0 : 1'($urandom % 2);
  end

  // receiver model, samples at the falling system clock edge
  bit started = 0, prev_mb = 0, lr_bad = 0, exp_urun = 0;
  int ncap = 0;
  logic [2*SW-1:0] fpair;
  logic [LW-1:0] capl, capr;
  always @(negedge clk) begin
    bit mb, ml;
    mb = (slave_c ? ext_bclk : bclk_o) ^ binv_c;
    ml = (slave_c ? ext_lrclk : lrclk_o) ^ lrinv_c;
    if (!rst_n || !(glb_en && tx_en)) begin
      started = 0;
    end else begin
      if (s_ready) begin
        if (started) check(ncap == 2*LW, "R11 one handshake per frame", ncap, 2*LW);
        fpair = s_valid ? s_data : '0;
        exp_urun = !s_valid;
        started = 1; ncap = 0; lr_bad = 0;
      end
      if (started && mb && !prev_mb && ncap < 2*LW) begin
        if (ncap == 0) check(underrun_o == exp_urun, "R12 underrun flag", underrun_o, exp_urun);
        if (ncap < LW) capl = {capl[LW-2:0], sd_o};
        else capr = {capr[LW-2:0], sd_o};
        if (ml != (ncap >= LW)) lr_bad = 1;
        ncap++;
        if (ncap == LW)
          check(capl == exp_word(fpair, 0, fmt_c, map_c, cnt_c), {ptag, " left slot"},
                capl, exp_word(fpair, 0, fmt_c, map_c, cnt_c));
        if (ncap == 2*LW) begin
          check(capr == exp_word(fpair, 1, fmt_c, map_c, cnt_c), {ptag, " right slot"},
                capr, exp_word(fpair, 1, fmt_c, map_c, cnt_c));
          check(!lr_bad, "R6 R7 frame clock level per slot", lr_bad, 0);
        end
      end
    end
    prev_mb = mb;
  end

  task automatic set_cfg(input bit sl, input logic [1:0] f, input bit bi, input bit li,
                         input logic [7:0] m, input logic [2:0] c, input int sv, input string t);
    @(posedge clk); #2;
    glb_en = 0; tx_en = 0;
    slave_c = sl; fmt_c = f; binv_c = bi; lrinv_c = li; map_c = m; cnt_c = c;
    starve = sv; ptag = t;
    ext_bclk = bi; ext_lrclk = 1'b1 ^ li;
    repeat (4) @(posedge clk);
  endtask

  task automatic run_master(input int cyc);
    @(posedge clk); #2;
    glb_en = 1; tx_en = 1;
    repeat (cyc) @(posedge clk);
    #2; tx_en = 0; glb_en = 0;
    repeat (6) @(posedge clk);
  endtask

  task automatic slave_bit(input int h);
    @(posedge clk); #2;
    ext_lrclk = 1'(h) ^ lrinv_c; ext_bclk = binv_c;
    repeat (8) @(posedge clk);
    #2; ext_bclk = ~binv_c;
    repeat (8) @(posedge clk);
  endtask

  task automatic run_slave(input int frames);
    @(posedge clk); #2;
    glb_en = 1; tx_en = 1;
    repeat (4) @(posedge clk);
    for (int b = 0; b < LW; b++) slave_bit(1);
    for (int f = 0; f < frames; f++)
      for (int h = 0; h < 2; h++)
        for (int b = 0; b < LW; b++) slave_bit(h);
    repeat (4) @(negedge clk);
    check(bclk_o == 0 && lrclk_o == 0, "R8 clock outputs low in follower mode", {bclk_o, lrclk_o}, 0);
    @(posedge clk); #2; tx_en = 0; glb_en = 0;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int changes;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    // R1 reset and idle state
    @(negedge clk);
    check({sd_o, s_ready, underrun_o, bclk_o, lrclk_o} == 0, "R1 reset state",
          {sd_o, s_ready, underrun_o, bclk_o, lrclk_o}, 0);
    changes = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk_o != 0 || lrclk_o != 0 || sd_o || s_ready) changes++;
    end
    check(changes == 0, "R1 idle while disabled despite ticks", changes, 0);

    set_cfg(0, 2'd0, 0, 0, 8'h10, 3'd1, 0, "R2 I2S");
    run_master(1250);
    set_cfg(0, 2'd1, 1, 0, 8'h10, 3'd1, 0, "R3 R5 left-justified inverted bclk");
    run_master(1250);
    set_cfg(0, 2'd2, 0, 1, 8'h10, 3'd1, 0, "R4 R6 right-justified inverted frame clock");
    run_master(1250);
    set_cfg(0, 2'd3, 1, 1, 8'h10, 3'd1, 0, "R2 reserved format as I2S");
    run_master(950);
    set_cfg(0, 2'd1, 0, 0, 8'h01, 3'd1, 0, "R9 swapped map");
    run_master(950);
    set_cfg(0, 2'd0, 0, 0, 8'h50, 3'd1, 0, "R9 out-of-range index");
    run_master(950);
    set_cfg(0, 2'd1, 0, 0, 8'h10, 3'd0, 0, "R10 one active slot");
    run_master(950);
    set_cfg(0, 2'd2, 0, 0, 8'h10, 3'd1, 2, "R12 random starvation");
    run_master(2600);
    set_cfg(0, 2'd0, 0, 0, 8'h10, 3'd1, 1, "R12 full starvation");
    run_master(950);

    for (int it = 0; it < 4; it++) begin
      logic [3:0] n0, n1;
      n0 = 4'($urandom % 3); n1 = 4'($urandom % 3);
      set_cfg(0, 2'($urandom), 1'($urandom), 1'($urandom), {n1, n0},
              3'($urandom % 4), 2 * int'($urandom % 2), "R9 random config");
      run_master(1000);
    end

    set_cfg(1, 2'd0, 0, 0, 8'h10, 3'd1, 0, "R8 follower I2S");
    run_slave(3);
    set_cfg(1, 2'd2, 1, 1, 8'h01, 3'd1, 2, "R8 follower right-justified inverted");
    run_slave(3);

    // R1 transmit enable dropped in mid-frame
    set_cfg(0, 2'd1, 0, 0, 8'h10, 3'd1, 0, "R1 stop");
    @(posedge clk); #2; glb_en = 1; tx_en = 1;
    repeat (700) @(posedge clk);
    #2; tx_en = 0;
    @(posedge clk);
    changes = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sd_o || s_ready || bclk_o != 0 || lrclk_o != 0) changes++;
    end
    check(changes == 0, "R1 quiet after tx_en cleared", changes, 0);
    // R1 global enable dropped in mid-frame
    @(posedge clk); #2; tx_en = 1;
    repeat (700) @(posedge clk);
    #2; glb_en = 0;
    @(posedge clk);
    changes = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sd_o || s_ready || underrun_o) changes++;
    end
    check(changes == 0, "R1 quiet after glb_en cleared", changes, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule